// File: doc/BRIEF.md
# Triggered Hit Recorder with Crossing Timestamp

This block is the acquisition-phase digital core of a multi-channel detector front end. Every channel brings in three discriminator bits (low, medium and high threshold). Each clock cycle is one bunch crossing. A free-running crossing counter numbers the cycles. In each cycle the block turns each channel's three bits into a 2-bit hit code. When the trigger condition holds, it stores one event record: every channel's code plus the crossing count of that cycle.

The trigger source is selected by a mode input. In self-trigger mode, a record is written whenever any channel's low-threshold bit is set. In external mode, only the external trigger input starts a write. Records go into an on-chip store in arrival order. Once the store holds its maximum number of records, a full flag rises and later triggers are dropped. A separate readout block reads the record count and fetches records by index during the readout phase.

Top module: `hit_event_store`

## Requirements
- R1: Each channel code is 3 (binary 11) when the high bit is set, otherwise 2 (10) when the medium bit is set, otherwise 1 (01) when the low bit is set, otherwise 0. Channel i occupies bits [2i+1:2i] of a record.
- R2: With `ext_mode` low, a record is written in a cycle exactly when at least one `disc_lo` bit is set. Medium or high bits alone write nothing.
- R3: With `ext_mode` high, a record is written in a cycle exactly when `ext_trig` is high. `disc_lo` has no effect on writing.
- R4: The crossing counter is 0 in the first cycle after reset and advances by one every clock, wrapping modulo 2^TS_W. A record stores the counter value of the cycle in which it is written.
- R5: A trigger held high over several cycles writes one record per cycle. Successive records carry successive counter values.
- R6: `evt_count` counts stored records, starting at index 0, and never exceeds DEPTH. `ram_full` is high exactly when `evt_count` equals DEPTH.
- R7: While `ram_full` is high, triggers are ignored. `evt_count` and the stored records stay unchanged.
- R8: A synchronous active-high `rst` clears the record count, the full flag and the crossing counter.
- R9: `rd_codes` and `rd_stamp` present the record at `rd_idx` one clock after `rd_idx` is applied. Both read as zero when `rd_idx` is not below `evt_count`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crossing clock, one cycle per bunch crossing |
| rst | input | 1 | Synchronous active-high reset |
| ext_mode | input | 1 | 1 selects the external trigger, 0 selects self-trigger |
| ext_trig | input | 1 | External trigger |
| disc_lo | input | N_CH | Low-threshold discriminator bits |
| disc_mid | input | N_CH | Medium-threshold discriminator bits |
| disc_hi | input | N_CH | High-threshold discriminator bits |
| ram_full | output | 1 | Store holds DEPTH records |
| evt_count | output | $clog2(DEPTH+1) | Number of stored records |
| rd_idx | input | $clog2(DEPTH+1) | Record index to read |
| rd_codes | output | 2*N_CH | Channel codes of the addressed record |
| rd_stamp | output | TS_W | Crossing count of the addressed record |

## Verification
A wrong count or pointer shows up on `evt_count` in the cycle after the faulty write. It then shows up again during readback, because a record sits in the wrong slot or holds stale data. A wrong trigger decision or a wrong full flag changes `evt_count` one clock after the offending cycle. A wrong counter phase or wrap shows up only when the record is read back, as an offset in `rd_stamp`. For this reason every test phase ends with a full readback, in which each stored record is compared with its expected value.

// File: rtl/hes_pkg.sv
package hes_pkg;

    typedef logic [1:0] hit_code_t;

    localparam hit_code_t CODE_NONE = 2'd0;
    localparam hit_code_t CODE_LOW  = 2'd1;
    localparam hit_code_t CODE_MID  = 2'd2;
    localparam hit_code_t CODE_HIGH = 2'd3;

    typedef struct packed {
        logic hi;
        logic mid;
        logic lo;
    } disc_t;

    // Highest set threshold wins, so non-monotonic inputs still map cleanly.
    function automatic hit_code_t encode_hit(input disc_t d);
        if (d.hi)       return CODE_HIGH;
        else if (d.mid) return CODE_MID;
        else if (d.lo)  return CODE_LOW;
        else            return CODE_NONE;
    endfunction

endpackage

// File: rtl/hes_encoder.sv
module hes_encoder
    import hes_pkg::*;
#(
    parameter int N_CH = 64
) (
    input  logic [N_CH-1:0]   disc_lo,
    input  logic [N_CH-1:0]   disc_mid,
    input  logic [N_CH-1:0]   disc_hi,
    output logic [2*N_CH-1:0] codes
);
    for (genvar i = 0; i < N_CH; i++) begin : g_ch
        disc_t d;
        always_comb begin
            d.lo  = disc_lo[i];
            d.mid = disc_mid[i];
            d.hi  = disc_hi[i];
            codes[2*i +: 2] = encode_hit(d);
        end
    end
endmodule

// File: rtl/hes_trigger.sv
module hes_trigger #(
    parameter int N_CH = 64
) (
    input  logic            ext_mode,
    input  logic            ext_trig,
    input  logic [N_CH-1:0] disc_lo,
    output logic            wr_req
);
    always_comb begin
        if (ext_mode) wr_req = ext_trig;
        else          wr_req = |disc_lo;
    end
endmodule

// File: rtl/hes_bx_counter.sv
module hes_bx_counter #(
    parameter int TS_W = 24
) (
    input  logic            clk,
    input  logic            rst,
    output logic [TS_W-1:0] bx
);
    always_ff @(posedge clk) begin
        if (rst) bx <= '0;
        else     bx <= bx + 1'b1;
    end
endmodule

// File: rtl/hes_event_mem.sv
module hes_event_mem #(
    parameter int N_CH  = 64,
    parameter int TS_W  = 24,
    parameter int DEPTH = 127,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int REC_W = 2 * N_CH + TS_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_req,
    input  logic [2*N_CH-1:0] wr_codes,
    input  logic [TS_W-1:0]   wr_stamp,
    input  logic [CNT_W-1:0]  rd_idx,
    output logic [CNT_W-1:0]  count,
    output logic              full,
    output logic [2*N_CH-1:0] rd_codes,
    output logic [TS_W-1:0]   rd_stamp
);
    logic [REC_W-1:0] store [DEPTH];
    logic [REC_W-1:0] rd_q;
    logic             do_wr;

    assign do_wr = wr_req && !full;

    // The record count doubles as the write address.
    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
            full  <= 1'b0;
        end else if (do_wr) begin
            count <= count + 1'b1;
            full  <= (count == CNT_W'(DEPTH - 1));
        end
    end

    always_ff @(posedge clk) begin
        if (do_wr) store[count] <= {wr_codes, wr_stamp};
    end

    always_ff @(posedge clk) begin
        if (rd_idx < count) rd_q <= store[rd_idx];
        else                rd_q <= '0;
    end

    assign rd_codes = rd_q[REC_W-1 -: 2*N_CH];
    assign rd_stamp = rd_q[TS_W-1:0];
endmodule

// File: rtl/hit_event_store.sv
module hit_event_store #(
    parameter int N_CH  = 64,
    parameter int TS_W  = 24,
    parameter int DEPTH = 127,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ext_mode,
    input  logic              ext_trig,
    input  logic [N_CH-1:0]   disc_lo,
    input  logic [N_CH-1:0]   disc_mid,
    input  logic [N_CH-1:0]   disc_hi,
    output logic              ram_full,
    output logic [CNT_W-1:0]  evt_count,
    input  logic [CNT_W-1:0]  rd_idx,
    output logic [2*N_CH-1:0] rd_codes,
    output logic [TS_W-1:0]   rd_stamp
);
    logic [2*N_CH-1:0] codes;
    logic              wr_req;
    logic [TS_W-1:0]   bx;

    hes_encoder #(.N_CH(N_CH)) u_enc (
        .disc_lo (disc_lo),
        .disc_mid(disc_mid),
        .disc_hi (disc_hi),
        .codes   (codes)
    );

    hes_trigger #(.N_CH(N_CH)) u_trig (
        .ext_mode(ext_mode),
        .ext_trig(ext_trig),
        .disc_lo (disc_lo),
        .wr_req  (wr_req)
    );

    hes_bx_counter #(.TS_W(TS_W)) u_bx (
        .clk(clk),
        .rst(rst),
        .bx (bx)
    );

    hes_event_mem #(.N_CH(N_CH), .TS_W(TS_W), .DEPTH(DEPTH)) u_mem (
        .clk     (clk),
        .rst     (rst),
        .wr_req  (wr_req),
        .wr_codes(codes),
        .wr_stamp(bx),
        .rd_idx  (rd_idx),
        .count   (evt_count),
        .full    (ram_full),
        .rd_codes(rd_codes),
        .rd_stamp(rd_stamp)
    );
endmodule

// File: rtl/hes_checks.sv
module hes_checks #(
    parameter int N_CH  = 64,
    parameter int DEPTH = 127,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             ext_mode,
    input logic             ext_trig,
    input logic [N_CH-1:0]  disc_lo,
    input logic             ram_full,
    input logic [CNT_W-1:0] evt_count
);
    logic rst_seen_q = 1'b0;
    always_ff @(posedge clk) rst_seen_q <= rst;

    // R8: the cycle after reset shows an empty store
    always @(posedge clk) begin
        if (rst_seen_q && !rst)
            assert_reset_clear_R8: assert (evt_count == '0 && !ram_full);
    end

    // R5: the count moves by at most one per cycle
    assert_single_step_R5: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (evt_count == $past(evt_count) || evt_count == $past(evt_count) + 1'b1));

    // R2: a low hit in self-trigger mode with room left adds a record
    assert_self_trig_R2: assert property (@(posedge clk) disable iff (rst)
        (!ext_mode && |disc_lo && !ram_full) |=> evt_count == $past(evt_count) + 1'b1);

    // R3: in external mode, no trigger means no write
    assert_ext_quiet_R3: assert property (@(posedge clk) disable iff (rst)
        (ext_mode && !ext_trig) |=> $stable(evt_count));

    // R7: a full store holds its count
    assert_hold_full_R7: assert property (@(posedge clk) disable iff (rst)
        ram_full |=> ($stable(evt_count) && ram_full));

    // R6: the count never passes DEPTH, and the flag matches it
    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (rst)
        (evt_count <= CNT_W'(DEPTH)) && (ram_full == (evt_count == CNT_W'(DEPTH))));
endmodule

bind hit_event_store hes_checks #(.N_CH(N_CH), .DEPTH(DEPTH)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .ext_mode (ext_mode),
    .ext_trig (ext_trig),
    .disc_lo  (disc_lo),
    .ram_full (ram_full),
    .evt_count(evt_count)
);

// File: tb/hit_event_store_tb.sv
module hit_event_store_tb;
    localparam int N     = 4;
    localparam int TS    = 5;
    localparam int DEPTH = 5;
    localparam int CW    = $clog2(DEPTH + 1);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ext_mode = 1'b0, ext_trig = 1'b0;
    logic [N-1:0]  lo = '0, mid = '0, hi = '0;
    logic          ram_full;
    logic [CW-1:0] evt_count;
    logic [CW-1:0] rd_idx = '0;
    logic [2*N-1:0] rd_codes;
    logic [TS-1:0] rd_stamp;

    int total = 0, bad = 0;
    int ticks = 0;
    int m_cnt = 0;
    logic [2*N-1:0] e_codes [DEPTH];
    logic [TS-1:0]  e_stamp [DEPTH];

    always #2 clk = ~clk;

    hit_event_store #(.N_CH(N), .TS_W(TS), .DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst(rst), .ext_mode(ext_mode), .ext_trig(ext_trig),
        .disc_lo(lo), .disc_mid(mid), .disc_hi(hi),
        .ram_full(ram_full), .evt_count(evt_count), .rd_idx(rd_idx),
        .rd_codes(rd_codes), .rd_stamp(rd_stamp)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [1:0] code_of(input logic l, input logic m, input logic h);
        return h ? 2'd3 : m ? 2'd2 : l ? 2'd1 : 2'd0;
    endfunction

    task automatic do_reset();
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        ticks = 0;
        m_cnt = 0;
        chk(evt_count == 0, "R8 count", evt_count, 0);
        chk(ram_full == 1'b0, "R8 full", ram_full, 0);
    endtask

    // Drives one cycle of inputs at the negedge and models the write.
    task automatic step(input logic mode, input logic trig,
                        input logic [N-1:0] l, input logic [N-1:0] m, input logic [N-1:0] h,
                        input string req);
        logic [2*N-1:0] c;
        bit wr;
        ext_mode = mode; ext_trig = trig; lo = l; mid = m; hi = h;
        for (int i = 0; i < N; i++) c[2*i +: 2] = code_of(l[i], m[i], h[i]);
        wr = mode ? trig : (|l);
        if (wr && m_cnt < DEPTH) begin
            e_codes[m_cnt] = c;
            e_stamp[m_cnt] = TS'(ticks);
            m_cnt++;
        end
        @(posedge clk);
        ticks++;
        @(negedge clk);
        chk(evt_count == CW'(m_cnt), req, evt_count, m_cnt);
        chk(ram_full == (m_cnt == DEPTH), "R6 full flag", ram_full, m_cnt == DEPTH);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) step(1'b0, 1'b0, '0, '0, '0, "R2 idle");
    endtask

    task automatic read_all();
        for (int i = 0; i <= DEPTH; i++) begin
            rd_idx = CW'(i);
            @(posedge clk);
            ticks++;
            @(negedge clk);
            if (i < m_cnt) begin
                chk(rd_codes == e_codes[i], "R1 codes", rd_codes, e_codes[i]);
                chk(rd_stamp == e_stamp[i], "R4 stamp", rd_stamp, e_stamp[i]);
            end else begin
                chk(rd_codes == '0 && rd_stamp == '0, "R9 out of range", rd_codes, 0);
            end
        end
        rd_idx = '0;
    endtask

    initial begin
        #1_000_000;
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [N-1:0] l, m, h;
        @(negedge clk);
        @(negedge clk);
        do_reset();

        // Self-trigger: medium/high without low writes nothing (R2)
        step(1'b0, 1'b0, '0, 4'b1111, 4'b0101, "R2 no low");
        step(1'b0, 1'b1, '0, '0, '0, "R2 ext ignored in self mode");
        // Sweep all 3-bit discriminator patterns per channel (R1, R2)
        for (int v = 0; v < 8; v++) begin
            for (int c = 0; c < N; c++) begin
                l[c] = ((v + c) % 8) & 1;
                m[c] = (((v + c) % 8) >> 1) & 1;
                h[c] = (((v + c) % 8) >> 2) & 1;
            end
            step(1'b0, 1'b0, l, m, h, "R2 sweep");
        end
        // Store is full; further triggers are ignored (R7)
        step(1'b0, 1'b0, 4'b1111, 4'b0011, 4'b0001, "R7 ignored");
        step(1'b1, 1'b1, 4'b1111, '0, '0, "R7 ignored ext");
        read_all();

        // External mode (R3, R5)
        do_reset();
        step(1'b1, 1'b0, 4'b1111, 4'b1111, 4'b1111, "R3 low ignored");
        step(1'b1, 1'b1, 4'b0000, 4'b0000, 4'b0000, "R3 ext write");
        step(1'b1, 1'b1, 4'b0010, 4'b0100, 4'b1000, "R5 held 1");
        step(1'b1, 1'b1, 4'b1001, 4'b1001, 4'b0000, "R5 held 2");
        idle(2);
        read_all();

        // Counter wrap (R4) after a reset mid-run (R8)
        do_reset();
        idle((1 << TS) - 2);
        for (int k = 0; k < 4; k++) step(1'b1, 1'b1, 4'(k), 4'(k + 1), '0, "R4 wrap");
        step(1'b0, 1'b0, 4'b0100, '0, '0, "R4 wrap self");
        chk(ram_full == 1'b1, "R6 full at depth", ram_full, 1);
        read_all();

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule